// File: doc/BRIEF.md
# Power-Gating Domain Sequencer

This block controls a switchable logic domain that can be powered down and powered back up. It accepts single-cycle sleep and wake requests and steps the domain through fixed sequences. Going down, it stops the domain clock, clamps the domain outputs with isolation, pulses a retention save strobe, and then opens every power-switch segment. Going up, it closes the switch segments one group at a time with a programmable spacing, so that inrush current builds gradually. It then waits for a power-good acknowledge, pulses a retention restore strobe, restarts the clock, and releases isolation as the final step.

Every wait on the switch network is bounded by a programmable timeout. If the acknowledge does not arrive in time, the sequencer parks in an error state. In that state isolation stays on, the clock stays off and the switches stay open, until an explicit clear returns it to the off state. A 3-bit status output reports the coarse state. Requests that arrive in the middle of a sequence are held, and they take effect only after that sequence has finished.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the status reads OFF (2), iso_en_o=1, clk_en_o=0, sw_en_o=0, save_o=0, restore_o=0 and err_o=0.
- R2: iso_en_o is 0 only while every sw_en_o bit is 1 and the status is ON (0) or GOING_OFF (1). In every other cycle it is 1.
- R3: Power-down runs in consecutive cycles. clk_en_o falls first. iso_en_o rises one cycle later. save_o is high for exactly one cycle, two cycles after the clock stops. All sw_en_o bits drop to 0 one cycle after the save pulse.
- R4: On power-up, sw_en_o fills from bit 0 upward, one bit at a time. Bit i rises exactly G cycles after bit i-1, where G is gap_cfg_i, or 1 when gap_cfg_i is 0.
- R5: After all segments are on and pwr_good_i has been seen high, restore_o is high for exactly one cycle. This happens in the cycle after the first cycle in which pwr_good_i is seen high. clk_en_o rises one cycle after restore_o, and iso_en_o falls one cycle after that.
- R6: A wake request that arrives during power-down does not abort it. The down sequence completes, the status reads OFF for at least one cycle, and the up sequence then runs to ON.
- R7: Each acknowledge wait counts its cycles from 0. An acknowledge seen in the cycle whose count equals tmo_cfg_i is accepted. If none has been seen by then, the sequencer enters ERROR (status 4). The power-down acknowledge is pwr_good_i low, and the power-up acknowledge is pwr_good_i high.
- R8: In ERROR, err_o=1, iso_en_o=1 and clk_en_o=0. sw_en_o is 0 from the second error cycle onward. The state holds until err_clr_i, after which the status reads OFF and err_o=0.
- R9: The status encodes the state as ON=0, GOING_OFF=1, OFF=2, GOING_ON=3 and ERROR=4. GOING_OFF covers the whole down sequence and GOING_ON covers the whole up sequence.
- R10: A wake request while ON and a sleep request while OFF are dropped. They have no effect at the time, and no effect after the next opposite transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-on clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| sleep_req_i | input | 1 | single-cycle power-down request |
| wake_req_i | input | 1 | single-cycle power-up request |
| err_clr_i | input | 1 | leave ERROR for OFF |
| gap_cfg_i | input | GAP_W | cycles between successive segment enables |
| tmo_cfg_i | input | TMO_W | acknowledge timeout in cycles |
| pwr_good_i | input | 1 | domain supply is up |
| clk_en_o | output | 1 | domain clock enable |
| iso_en_o | output | 1 | output isolation clamp |
| save_o | output | 1 | retention save strobe |
| restore_o | output | 1 | retention restore strobe |
| sw_en_o | output | NUM_SEG | per-segment power-switch enables |
| state_o | output | 3 | coarse status code |
| err_o | output | 1 | timeout error, held until cleared |

## Verification
A supply model acknowledges after a settable delay. It runs fixed and random combinations of segment gap, including a gap of zero, together with power-up and power-down delays. These runs show whether the spacing of the segments and the order of the strobes hold for any timing, rather than only for one alignment. Directed patterns cover the remaining cases. An acknowledge landing exactly on the timeout, and one a cycle later, tell an off-by-one apart. A wake arriving mid-shutdown tells a completed sequence from an aborted one. Redundant requests, followed by an opposite transition, tell a dropped request from one that is silently kept pending.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [3:0] {
    PH_ON,
    PH_D_CLK,
    PH_D_ISO,
    PH_D_SAVE,
    PH_D_SW,
    PH_OFF,
    PH_U_SW,
    PH_U_WAIT,
    PH_U_REST,
    PH_U_CLK,
    PH_ERR
  } phase_e;

  typedef enum logic [2:0] {
    ST_ON       = 3'd0,
    ST_GOING_OFF = 3'd1,
    ST_OFF      = 3'd2,
    ST_GOING_ON = 3'd3,
    ST_ERROR    = 3'd4
  } status_e;

  function automatic status_e status_of(phase_e p);
    case (p)
      PH_ON:                                   return ST_ON;
      PH_D_CLK, PH_D_ISO, PH_D_SAVE, PH_D_SW:  return ST_GOING_OFF;
      PH_OFF:                                  return ST_OFF;
      PH_ERR:                                  return ST_ERROR;
      default:                                 return ST_GOING_ON;
    endcase
  endfunction

endpackage

// File: rtl/pgs_req_latch.sv
module pgs_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic drop_i,
  output logic pend_sleep_o,
  output logic pend_wake_o
);
  logic sleep_q, wake_q;

  // newest request wins; stable states discard whatever is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      sleep_q <= (sleep_req_i & ~wake_req_i) | (sleep_q & ~wake_req_i & ~drop_i);
      wake_q  <= wake_req_i | (wake_q & ~sleep_req_i & ~drop_i);
    end
  end

  assign pend_sleep_o = sleep_q;
  assign pend_wake_o  = wake_q;

endmodule

// File: rtl/pgs_stager.sv
module pgs_stager #(
  parameter int NUM_SEG = 4,
  parameter int GAP_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic [GAP_W-1:0]   gap_i,
  output logic [NUM_SEG-1:0] sw_en_o,
  output logic               done_o
);
  localparam logic [NUM_SEG-1:0] SEG_ONE = NUM_SEG'(1);

  logic [NUM_SEG-1:0] sw_q;
  logic [GAP_W-1:0]   cnt_q, gap_last;
  logic               stepping;

  assign gap_last = (gap_i == '0) ? '0 : gap_i - GAP_W'(1);
  assign done_o   = &sw_q;
  assign stepping = sw_q[0] & ~done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      sw_q  <= SEG_ONE;
      cnt_q <= '0;
    end else if (clear_i) begin
      sw_q  <= '0;
      cnt_q <= '0;
    end else if (stepping) begin
      if (cnt_q == gap_last) begin
        sw_q  <= sw_q | (sw_q << 1);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + GAP_W'(1);
      end
    end
  end

  assign sw_en_o = sw_q;

  assert_thermometer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_q + SEG_ONE) & sw_q) == '0);

  assert_one_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sw_q & ~$past(sw_q)) <= 1);

endmodule

// File: rtl/pgs_timer.sv
module pgs_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             hit_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + TMO_W'(1);
  end

  assign hit_o = run_i & (cnt_q >= tmo_i);

  assert_count_from_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int NUM_SEG = 4,
  parameter int GAP_W   = 8,
  parameter int TMO_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic               wake_req_i,
  input  logic               err_clr_i,
  input  logic [GAP_W-1:0]   gap_cfg_i,
  input  logic [TMO_W-1:0]   tmo_cfg_i,
  input  logic               pwr_good_i,
  output logic               clk_en_o,
  output logic               iso_en_o,
  output logic               save_o,
  output logic               restore_o,
  output logic [NUM_SEG-1:0] sw_en_o,
  output logic [2:0]         state_o,
  output logic               err_o
);
  import pgs_pkg::*;

  localparam logic [NUM_SEG-1:0] SEG_ALL = '1;

  phase_e phase_q, phase_d;
  logic   pend_sleep, pend_wake, seg_done, tmo_hit;
  logic   wait_run, stage_start, stage_clear, req_drop;

  assign req_drop    = (phase_q == PH_ON) | (phase_q == PH_OFF);
  assign wait_run    = (phase_q == PH_D_SW) | (phase_q == PH_U_WAIT);
  assign stage_start = (phase_q == PH_OFF) & pend_wake;
  assign stage_clear = (phase_q == PH_D_SAVE) | (phase_q == PH_ERR);

  pgs_req_latch u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .wake_req_i   (wake_req_i),
    .drop_i       (req_drop),
    .pend_sleep_o (pend_sleep),
    .pend_wake_o  (pend_wake)
  );

  pgs_stager #(.NUM_SEG(NUM_SEG), .GAP_W(GAP_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stage_start),
    .clear_i (stage_clear),
    .gap_i   (gap_cfg_i),
    .sw_en_o (sw_en_o),
    .done_o  (seg_done)
  );

  pgs_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (wait_run),
    .tmo_i  (tmo_cfg_i),
    .hit_o  (tmo_hit)
  );

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_ON:     if (pend_sleep) phase_d = PH_D_CLK;
      PH_D_CLK:  phase_d = PH_D_ISO;
      PH_D_ISO:  phase_d = PH_D_SAVE;
      PH_D_SAVE: phase_d = PH_D_SW;
      PH_D_SW:   if (!pwr_good_i) phase_d = PH_OFF;
                 else if (tmo_hit) phase_d = PH_ERR;
      PH_OFF:    if (pend_wake) phase_d = PH_U_SW;
      PH_U_SW:   if (seg_done) phase_d = PH_U_WAIT;
      PH_U_WAIT: if (pwr_good_i) phase_d = PH_U_REST;
                 else if (tmo_hit) phase_d = PH_ERR;
      PH_U_REST: phase_d = PH_U_CLK;
      PH_U_CLK:  phase_d = PH_ON;
      PH_ERR:    if (err_clr_i) phase_d = PH_OFF;
      default:   phase_d = PH_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_OFF;
    else         phase_q <= phase_d;
  end

  assign clk_en_o  = (phase_q == PH_ON) | (phase_q == PH_U_CLK);
  assign iso_en_o  = ~((phase_q == PH_ON) | (phase_q == PH_D_CLK));
  assign save_o    = (phase_q == PH_D_SAVE);
  assign restore_o = (phase_q == PH_U_REST);
  assign err_o     = (phase_q == PH_ERR);
  assign state_o   = status_of(phase_q);

  assert_iso_unpowered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o != SEG_ALL) |-> iso_en_o);

  assert_clk_powered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (sw_en_o == SEG_ALL));

  assert_save_context_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |-> (iso_en_o && !clk_en_o && sw_en_o == SEG_ALL));

  assert_save_then_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> (!save_o && sw_en_o == '0));

  assert_restore_context_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (iso_en_o && !clk_en_o && sw_en_o == SEG_ALL && $past(pwr_good_i)));

  assert_iso_release_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_en_o) |-> ($past(clk_en_o) && !$past(restore_o)));

  assert_err_safe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (iso_en_o && !clk_en_o));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  assert_status_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

endmodule

// File: tb/sim_pwr_domain_seq.sv
`timescale 1ns/1ps
module sim_pwr_domain_seq;
  localparam int NS = 4;
  localparam int GW = 8;
  localparam int TW = 16;
  localparam logic [NS-1:0] ALL = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, err_clr = 1'b0;
  logic [GW-1:0] gap = 8'd1;
  logic [TW-1:0] tmo = 16'd20;
  logic pg;
  logic clk_en, iso, save, restore, err;
  logic [NS-1:0] sw;
  logic [2:0] st;

  always #2 clk = ~clk;

  pwr_domain_seq #(.NUM_SEG(NS), .GAP_W(GW), .TMO_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .err_clr_i(err_clr), .gap_cfg_i(gap), .tmo_cfg_i(tmo), .pwr_good_i(pg),
    .clk_en_o(clk_en), .iso_en_o(iso), .save_o(save), .restore_o(restore),
    .sw_en_o(sw), .state_o(st), .err_o(err));

  // supply model: acknowledges a settable number of cycles after the switches settle
  int d_on = 1, d_off = 1, on_c, off_c;
  bit dead_on = 0, dead_off = 0;
  logic [NS-1:0] sw_s = '0;
  always @(negedge clk) sw_s <= sw;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg <= 1'b0; on_c <= 0; off_c <= 0;
    end else if (sw_s == ALL) begin
      off_c <= 0;
      if (!pg && !dead_on) begin
        if (on_c >= d_on - 1) pg <= 1'b1; else on_c <= on_c + 1;
      end
    end else if (sw_s == '0) begin
      on_c <= 0;
      if (pg && !dead_off) begin
        if (off_c >= d_off - 1) pg <= 1'b0; else off_c <= off_c + 1;
      end
    end else begin
      on_c <= 0; off_c <= 0;
    end
  end

  // event monitor
  int cyc = 0, inv_bad = 0;
  int t_sw [NS];
  int t_pg, t_rest, t_clk_on, t_clk_off, t_iso_on, t_iso_off, t_save, t_sw_off;
  int rest_w, save_w;
  bit saw_gon, saw_goff, saw_off;
  logic [NS-1:0] p_sw = '0;
  logic p_pg = 0, p_rest = 0, p_clk = 0, p_iso = 1, p_save = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < NS; i++) if (sw[i] && !p_sw[i]) t_sw[i] = cyc;
      if (pg && !p_pg) t_pg = cyc;
      if (restore && !p_rest) t_rest = cyc;
      if (restore) rest_w++;
      if (clk_en && !p_clk) t_clk_on = cyc;
      if (!clk_en && p_clk) t_clk_off = cyc;
      if (iso && !p_iso) t_iso_on = cyc;
      if (!iso && p_iso) t_iso_off = cyc;
      if (save && !p_save) t_save = cyc;
      if (save) save_w++;
      if (sw == '0 && p_sw != '0) t_sw_off = cyc;
      if (st == 3'd3) saw_gon = 1;
      if (st == 3'd1) saw_goff = 1;
      if (st == 3'd2) saw_off = 1;
      if (!iso && (sw != ALL || !(st == 3'd0 || st == 3'd1))) inv_bad++;
    end
    p_sw = sw; p_pg = pg; p_rest = restore; p_clk = clk_en; p_iso = iso; p_save = save;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clear_marks();
    for (int i = 0; i < NS; i++) t_sw[i] = -1;
    t_pg = -1; t_rest = -1; t_clk_on = -1; t_clk_off = -1;
    t_iso_on = -1; t_iso_off = -1; t_save = -1; t_sw_off = -1;
    rest_w = 0; save_w = 0; saw_gon = 0; saw_goff = 0; saw_off = 0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) sleep_req = 1; else if (which == 1) wake_req = 1; else err_clr = 1;
    @(negedge clk);
    sleep_req = 0; wake_req = 0; err_clr = 0;
    #1;
  endtask

  task automatic wait_st(int code, int max, output bit ok);
    ok = 0;
    for (int i = 0; i < max && !ok; i++) begin
      tick(1);
      if (st == 3'(code)) ok = 1;
    end
  endtask

  function automatic int gap_eff(int g);
    return (g == 0) ? 1 : g;
  endfunction

  task automatic check_up(int g);
    for (int i = 1; i < NS; i++)
      chk(t_sw[i] - t_sw[i-1] == gap_eff(g), "R4 segment spacing", t_sw[i] - t_sw[i-1], gap_eff(g));
    chk(t_sw[0] >= 0 && t_pg > t_sw[NS-1], "R5 power good after last segment", t_pg, t_sw[NS-1] + 1);
    chk(t_rest == t_pg + 1 && rest_w == 1, "R5 restore one cycle after power good", t_rest, t_pg + 1);
    chk(t_clk_on == t_rest + 1, "R5 clock after restore", t_clk_on, t_rest + 1);
    chk(t_iso_off == t_clk_on + 1, "R5 isolation released last", t_iso_off, t_clk_on + 1);
    chk(saw_gon == 1, "R9 GOING_ON code 3 seen", int'(saw_gon), 1);
  endtask

  task automatic check_down();
    chk(t_clk_off >= 0 && t_iso_on == t_clk_off + 1, "R3 isolate after clock stop", t_iso_on, t_clk_off + 1);
    chk(t_save == t_clk_off + 2 && save_w == 1, "R3 single save pulse", t_save, t_clk_off + 2);
    chk(t_sw_off == t_clk_off + 3, "R3 switches off after save", t_sw_off, t_clk_off + 3);
    chk(saw_goff == 1, "R9 GOING_OFF code 1 seen", int'(saw_goff), 1);
  endtask

  task automatic do_wake(int g);
    bit ok;
    gap = GW'(g);
    clear_marks();
    pulse(1);
    wait_st(0, 3000, ok);
    chk(ok, "R9 ON code 0 reached", int'(st), 0);
    tick(2);
    check_up(g);
  endtask

  task automatic do_sleep();
    bit ok;
    clear_marks();
    pulse(0);
    wait_st(2, 3000, ok);
    chk(ok, "R9 OFF code 2 reached", int'(st), 2);
    tick(2);
    check_down();
  endtask

  task automatic hold_check(int code, string req);
    bit same = 1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (st != 3'(code) || (code == 0 && (!clk_en || iso)) || (code == 2 && (clk_en || !iso || sw != '0)))
        same = 0;
    end
    chk(same, req, int'(st), code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd4242));
    clear_marks();
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 reset state
    chk(st == 3'd2, "R1 status OFF", int'(st), 2);
    chk(iso == 1 && clk_en == 0, "R1 iso high clock off", {30'd0, iso, clk_en}, 2);
    chk(sw == '0 && !save && !restore && !err, "R1 switches and strobes idle", int'(sw), 0);

    d_on = 2; d_off = 3;
    do_wake(3);
    // R10 wake while ON dropped
    pulse(1);
    hold_check(0, "R10 wake while ON ignored");
    do_sleep();
    hold_check(2, "R10 stale wake not replayed after sleep");
    pulse(0);
    hold_check(2, "R10 sleep while OFF ignored");
    do_wake(0);
    hold_check(0, "R10 stale sleep not replayed after wake");
    do_sleep();

    // random timing mix
    for (int k = 0; k < 8; k++) begin
      d_on = 1 + int'($urandom % 6);
      d_off = 1 + int'($urandom % 6);
      do_wake(int'($urandom % 6));
      do_sleep();
    end

    // R6 wake during power-down
    d_on = 1; d_off = 4;
    do_wake(2);
    clear_marks();
    pulse(0);
    pulse(1);
    wait_st(0, 3000, ok);
    tick(2);
    chk(ok && saw_off, "R6 OFF passed before ON", int'(saw_off), 1);
    chk(t_sw_off >= 0 && save_w == 1, "R6 down sequence completed", save_w, 1);
    check_up(2);

    // R7 boundary: acknowledge exactly at the limit
    tmo = 16'd5; d_off = 5;
    do_sleep();
    chk(err == 0 && st == 3'd2, "R7 ack at limit accepted", int'(st), 2);
    do_wake(1);
    d_off = 6;
    clear_marks();
    pulse(0);
    wait_st(4, 100, ok);
    chk(ok, "R7 late ack gives ERROR", int'(st), 4);
    chk(err && iso && !clk_en, "R8 error safe outputs", {29'd0, err, iso, clk_en}, 6);
    tick(1);
    chk(sw == '0, "R8 switches open in error", int'(sw), 0);
    tick(10);
    chk(st == 3'd4 && err, "R8 error held", int'(st), 4);
    pulse(2);
    chk(st == 3'd2 && !err, "R8 clear returns OFF", int'(st), 2);

    // R7 power-up timeout
    tmo = 16'd8; dead_on = 1;
    clear_marks();
    pulse(1);
    wait_st(4, 200, ok);
    chk(ok && err, "R7 power-up timeout", int'(st), 4);
    tick(2);
    chk(sw == '0 && iso && !clk_en, "R8 safe after up timeout", int'(sw), 0);
    pulse(2);
    dead_on = 0; tmo = 16'd20;
    chk(st == 3'd2, "R8 cleared to OFF", int'(st), 2);
    do_wake(2);
    do_sleep();

    chk(inv_bad == 0, "R2 isolation invariant", inv_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule